// File: doc/BRIEF.md
# Read Data Window Edge Detector

This block judges, one delay tap at a time, whether the read data captured from a byte lane is stable and whether the data window edge has been crossed. A tap-change pulse starts each tap. Samples are not used until a settle-done signal arrives. After that, the block takes exactly 2^SAMP_LOG valid samples of the byte. Each bit is then reduced to one value by majority vote. The block compares the result with the value kept from the previous tap.

A saturating stability count filters out false edges in jittery regions. The count rises by one for each tap whose value matches the previous tap. It stops at 3. It returns to 0 whenever the value changes. A mismatch is reported as a real window edge only when the count stood at 3 before that mismatch. Delay stepping and command sequencing are left to the surrounding calibration logic.

Top module: `win_edge_detect`

## Requirements
- R1: After reset, `result_vld`, `mismatch`, `edge_det`, `stable` and `stable_cnt` are all 0.
- R2: A sample is counted only when `rd_valid` is high in a cycle after the cycle in which `settle_done` was seen. `settle_done` must itself come after the most recent `tap_step`. Valid samples before that point, and in the `settle_done` cycle itself, are ignored.
- R3: Once 2^SAMP_LOG samples have been counted, the decision appears on the following cycle. At that point `result_vld` pulses high for exactly one cycle.
- R4: Each bit of the averaged value is 1 when at least 2^SAMP_LOG/2 of its counted samples were 1. Otherwise the bit is 0. An exact half counts as 1.
- R5: `mismatch` is 1 when the averaged value differs in any bit from the value of the previous decision. The first decision after reset reports `mismatch` 0 and leaves `stable_cnt` at 0.
- R6: On a decision without a mismatch, `stable_cnt` (2 bits) increments. It saturates at 3.
- R7: On a decision with a mismatch, `stable_cnt` returns to 0.
- R8: `stable` is 1 exactly when the decision leaves `stable_cnt` at 3.
- R9: `edge_det` is 1 only for a decision with a mismatch for which `stable_cnt` was 3 before that decision.
- R10: `tap_step` discards the tap's partial samples and requires a new `settle_done`. It takes priority over a sample in the same cycle, even the final one. In that case no decision is made.
- R11: Valid samples that arrive after a decision, and before the next `tap_step`, are ignored.
- R12: `mismatch`, `edge_det`, `stable` and `stable_cnt` hold their values between decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_step | input | 1 | Pulse: delay tap has changed |
| settle_done | input | 1 | Pulse: settling time after the tap change has elapsed |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | W | Sampled byte lane data |
| result_vld | output | 1 | One-cycle pulse when a tap decision is made |
| mismatch | output | 1 | Averaged value differs from the previous tap's value |
| edge_det | output | 1 | Mismatch following a stable region (window edge) |
| stable | output | 1 | Stability count is at 3 |
| stable_cnt | output | 2 | Saturating stability count |

## Verification
The bench checks the case where the final sample of a tap and a new `tap_step` arrive in the same cycle. It drives one sample short of a full set, then presents the last sample together with `tap_step`. The expected result is no `result_vld` pulse and unchanged outputs. The following full tap must then decide on its own samples only, with the stability count continuing from the previous decision. The bench also drives `settle_done` in the same cycle as a valid sample of inverted data. If that sample were counted, it would flip the majority of the affected bits and show up as a wrong mismatch.

// File: rtl/win_edge_detect.sv
module win_edge_detect #(
  parameter int W        = 8,
  parameter int SAMP_LOG = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tap_step,
  input  logic         settle_done,
  input  logic         rd_valid,
  input  logic [W-1:0] rd_data,
  output logic         result_vld,
  output logic         mismatch,
  output logic         edge_det,
  output logic         stable,
  output logic [1:0]   stable_cnt
);
  localparam int N    = 1 << SAMP_LOG;
  localparam int AW   = SAMP_LOG + 1;
  localparam logic [AW-1:0] HALF = AW'(N / 2);
  localparam logic [SAMP_LOG-1:0] LAST = SAMP_LOG'(N - 1);

  logic                armed, done, have_prev;
  logic [SAMP_LOG-1:0] cnt;
  logic [AW-1:0]       acc [W];
  logic [W-1:0]        prev, avg;

  wire take  = armed && !done && rd_valid && !tap_step;
  wire final_s = take && (cnt == LAST);
  wire diff  = have_prev && (avg != prev);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign avg[b] = (acc[b] + AW'(rd_data[b])) >= HALF;
    always_ff @(posedge clk) begin
      if (!rst_n || tap_step) acc[b] <= '0;
      else if (take)          acc[b] <= acc[b] + AW'(rd_data[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else if (tap_step) begin
      armed <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (settle_done) armed <= 1'b1;
      if (take) cnt <= cnt + 1'b1;
      if (final_s) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_vld <= 1'b0;
      mismatch   <= 1'b0;
      edge_det   <= 1'b0;
      stable     <= 1'b0;
      stable_cnt <= '0;
      prev       <= '0;
      have_prev  <= 1'b0;
    end else begin
      result_vld <= final_s;
      if (final_s) begin
        prev      <= avg;
        have_prev <= 1'b1;
        mismatch  <= diff;
        edge_det  <= diff && (stable_cnt == 2'd3);
        if (diff) begin
          stable_cnt <= 2'd0;
          stable     <= 1'b0;
        end else if (have_prev) begin
          if (stable_cnt != 2'd3) stable_cnt <= stable_cnt + 2'd1;
          stable <= (stable_cnt >= 2'd2);
        end
      end
    end
  end
endmodule

module win_edge_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tap_step,
  input logic       result_vld,
  input logic       mismatch,
  input logic       edge_det,
  input logic       stable,
  input logic [1:0] stable_cnt
);
  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);
  p_mm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld && mismatch) |-> stable_cnt == 2'd0);
  p_stable_at3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stable |-> stable_cnt == 2'd3);
  p_edge_mm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |-> mismatch);
  p_edge_prev3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld && edge_det) |-> $past(stable_cnt) == 2'd3);
  p_step_nodec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_step |=> !result_vld);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> ($stable(stable_cnt) && $stable(mismatch) && $stable(edge_det)));
endmodule

bind win_edge_detect win_edge_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tap_step(tap_step), .result_vld(result_vld),
  .mismatch(mismatch), .edge_det(edge_det), .stable(stable), .stable_cnt(stable_cnt)
);

// File: tb/win_edge_detect_tb.sv
module win_edge_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int SL = 3;
  localparam int N = 1 << SL;

  logic clk = 0, rst_n = 0, tap_step = 0, settle_done = 0, rd_valid = 0;
  logic [W-1:0] rd_data = '0;
  logic result_vld, mismatch, edge_det, stable;
  logic [1:0] stable_cnt;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_prev = '0;
  bit m_have = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_edge_detect #(.W(W), .SAMP_LOG(SL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tap_step(tap_step), .settle_done(settle_done),
    .rd_valid(rd_valid), .rd_data(rd_data), .result_vld(result_vld),
    .mismatch(mismatch), .edge_det(edge_det), .stable(stable), .stable_cnt(stable_cnt));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] samp(logic [W-1:0] hi, int oh, int ol, int i);
    logic [W-1:0] s;
    for (int b = 0; b < W; b++) s[b] = hi[b] ? (i < oh) : (i < ol);
    return s;
  endfunction

  task automatic check_outs(string req, int emm, int eedge, int ecnt);
    chk({req, " mismatch"}, mismatch, emm);
    chk({req, " edge"}, edge_det, eedge);
    chk({req, " count"}, stable_cnt, ecnt);
    chk({req, " stable"}, stable, ecnt == 3);
  endtask

  // R2, R3, R4..R9, R11
  task automatic run_tap(logic [W-1:0] hi, int oh, int ol);
    logic [W-1:0] avg;
    int emm, eedge;
    @(negedge clk); tap_step = 1;
    @(negedge clk); tap_step = 0; rd_valid = 1; rd_data = '1;
    @(negedge clk); settle_done = 1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk); settle_done = 0; rd_valid = 1; rd_data = samp(hi, oh, ol, i);
      if (i < N - 1) chk("R3 no early decision", result_vld, 0);
    end
    @(negedge clk); rd_valid = 0;
    for (int b = 0; b < W; b++) avg[b] = (hi[b] ? oh : ol) >= N / 2;
    emm = m_have && (avg != m_prev);
    eedge = emm && (m_cnt == 3);
    if (emm) m_cnt = 0;
    else if (m_have && m_cnt < 3) m_cnt++;
    m_prev = avg; m_have = 1;
    chk("R3 result_vld", result_vld, 1);
    check_outs("R4-R9 decision", emm, eedge, m_cnt);
    for (int k = 0; k < 3; k++) begin
      rd_valid = 1; rd_data = ~avg;
      @(negedge clk);
      chk("R11 no decision after done", result_vld, 0);
      check_outs("R12 hold", emm, eedge, m_cnt);
    end
    rd_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outs("R1 reset", 0, 0, 0);
    chk("R1 result_vld", result_vld, 0);
    rst_n = 1;
    run_tap(8'h3C, 5, 3);   // R5 first decision
    run_tap(8'h3C, 4, 2);   // R4 tie counts as 1, R6
    run_tap(8'h3C, 8, 0);
    run_tap(8'h3C, 6, 1);   // reaches 3, R8
    run_tap(8'h3C, 7, 3);   // R6 saturation
    run_tap(8'h3D, 5, 3);   // R9 edge, R7
    run_tap(8'h3D, 5, 3);
    run_tap(8'h00, 5, 3);   // mismatch without edge
    // R10: tap_step collides with the final sample
    @(negedge clk); tap_step = 1;
    @(negedge clk); tap_step = 0; settle_done = 1;
    for (int i = 0; i < N - 1; i++) begin
      @(negedge clk); settle_done = 0; rd_valid = 1; rd_data = 8'hFF;
    end
    @(negedge clk); tap_step = 1;
    @(negedge clk); tap_step = 0; rd_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 no decision on collision", result_vld, 0);
      check_outs("R10 outputs held", 1, 0, 0);
      @(negedge clk);
    end
    run_tap(8'h00, 0, 0);   // R10 fresh tap decides on own samples
    for (int k = 0; k <= N; k++) run_tap(8'hFF, k, k);   // R4 sweep
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule